// File: doc/BRIEF.md
# Debug-Haltable PWM Timer

A 32-bit timer that produces a pulse-width-modulated output from two programmable values: a period length and a high-time width. The counter runs from 1 up to the period value and then wraps back to 1. At each wrap it raises a sticky interrupt flag and commits any period or width value that software wrote while the timer was running. Because updates are deferred this way, a period in progress is never cut short or lengthened by a late write.

A debug-halt input lets the timer stop along with a halted processor core. While the halt is asserted the count freezes, so the output waveform is stretched, but its level stays steady. A run-in-debug configuration bit makes the timer ignore the halt. Register access and the interrupt flag keep working through a halt.

The register bus is a single-cycle write strobe with a two-bit word address. Read data is combinational from the address. The register map is:

| Address | Register | Access |
|---|---|---|
| 0 | control | bit 0 enable, bit 1 run-in-debug, bit 2 interrupt flag (reads the flag; writing 1 clears it) |
| 1 | period | write shadow; reads the active value |
| 2 | width | write shadow; reads the active value |
| 3 | count | read only |

Top module: `dbg_pwm_timer`

## Requirements
- R1: After reset the count reads 1, the control register reads 0, and the active period and width read 0. The PWM output and the interrupt line are low.
- R2: Writing control with bit 0 set while the timer is disabled loads the count to 1 at that edge. The count then rises by 1 each clock.
- R3: In a clock where the timer is enabled, counting, and the count equals the active period, the next count is 1 and the interrupt flag (control bit 2, `irq_o`) becomes 1. The count never exceeds the active period.
- R4: The PWM output is registered. It is high in the clock after a clock in which the timer is enabled and the count is at most the active width. Over one full period it is high for min(width, period) clocks out of period clocks.
- R5: A write to period (address 1) or width (address 2) while the timer is enabled goes to a shadow register. The value read back stays unchanged until the next period boundary, and then becomes the written value.
- R6: A period or width write that lands in the boundary clock itself is committed at that same boundary.
- R7: A period or width write while the timer is disabled changes the active value at once.
- R8: While `dbg_halt_i` is high and run-in-debug (control bit 1) is 0, the count and the PWM output hold their values.
- R9: While `dbg_halt_i` is high and run-in-debug is 1, the count advances by 1 per clock as it does without a halt.
- R10: During a halt, register writes and reads work and a set interrupt flag stays set. Writing control with bit 2 set clears the flag, except in a boundary clock, where setting the flag wins.
- R11: Writing control with bit 0 clear stops the count at its current value. The PWM output reads 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_halt_i | input | 1 | Debug halt request from the core |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Sticky period interrupt flag |

## Verification
Two pairs of functions can fall in the same clock: a period write and the period boundary, and a flag-clear write and the flag being set by the boundary. The bench polls the count until it equals the period. It then issues the write so that it is captured on exactly the wrapping edge. It then judges three things: the count reads 1, the read-back period is the new value, and the interrupt flag is still 1 after the clear attempt. A halt is held for several clocks, once with run-in-debug clear and once with it set, and the count is read at the start and at the end.

// File: rtl/dbg_pwm_timer_pkg.sv
// Package: shared register map and field positions for the PWM timer.
// Assumes a word-addressed bus with four registers.
package dbg_pwm_timer_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_WIDTH  = 2'd2,
        REG_COUNT  = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RUN_BIT = 1;
    localparam int CTRL_IRQ_BIT = 2;
    localparam int CTRL_W       = 3;
endpackage

// File: rtl/tmr_ctrl.sv
// Module: tmr_ctrl
// Holds the enable and run-in-debug bits and the sticky interrupt flag.
// Produces a start pulse when the timer goes from disabled to enabled.
// Assumes the boundary pulse comes from the counter in the same clock.
module tmr_ctrl
    import dbg_pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              boundary_i,
    output logic              en_o,
    output logic              run_o,
    output logic              irq_o,
    output logic              start_o
);
    logic irq_clr;

    // Start pulse: enable is being set while the timer is off.
    assign start_o = ctrl_wr_i && ctrl_wdata_i[CTRL_EN_BIT] && !en_o;
    assign irq_clr = ctrl_wr_i && ctrl_wdata_i[CTRL_IRQ_BIT];

    // Configuration bits are written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            run_o <= 1'b0;
        end else if (ctrl_wr_i) begin
            en_o  <= ctrl_wdata_i[CTRL_EN_BIT];
            run_o <= ctrl_wdata_i[CTRL_RUN_BIT];
        end
    end

    // Sticky flag: the boundary sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_o <= 1'b0;
        else if (boundary_i) irq_o <= 1'b1;
        else if (irq_clr)    irq_o <= 1'b0;
    end

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i |=> irq_o);
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o);
endmodule

// File: rtl/tmr_shadow_reg.sv
// Module: tmr_shadow_reg
// Shadow and active register pair for a period or width value.
// While the timer is enabled a write lands in the shadow only. The shadow
// moves to the active register at the boundary, and a write in the boundary
// clock goes straight through. While the timer is disabled a write updates
// both registers.
module tmr_shadow_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en_i,
    input  logic              boundary_i,
    output logic [DATA_W-1:0] active_o
);
    logic [DATA_W-1:0] shadow_q;

    // Shadow capture: every write is kept for the next reload.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (wr_i) shadow_q <= wdata_i;
    end

    // Active value: direct when off, otherwise only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                        active_o <= '0;
        else if (wr_i && (!en_i || boundary_i)) active_o <= wdata_i;
        else if (boundary_i)               active_o <= shadow_q;
    end

    p_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !boundary_i) |=> $stable(active_o));
    p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !en_i) |=> (active_o == $past(wdata_i)));
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && boundary_i) |=> (active_o == $past(wdata_i)));
endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// Up-counter from RST_COUNT to the active period, then wraps.
// A debug halt gates the count unless run-in-debug is set.
// Assumes the period is at least RST_COUNT for normal wrapping.
module tmr_count #(
    parameter int          CNT_W     = 32,
    parameter logic [31:0] RST_COUNT = 32'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             run_i,
    input  logic             start_i,
    input  logic             halt_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o
);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_COUNT);

    logic tick;

    assign tick       = !halt_i || run_i;
    assign boundary_o = en_i && tick && (cnt_o == period_i);

    // Counter: restart on enable, advance on tick, reload at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_o <= CNT_INIT;
        else if (start_i)      cnt_o <= CNT_INIT;
        else if (boundary_o)   cnt_o <= CNT_INIT;
        else if (en_i && tick) cnt_o <= cnt_o + 1'b1;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == CNT_INIT));
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> (cnt_o == CNT_INIT));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !run_i && !start_i) |=> $stable(cnt_o));
    p_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && halt_i && run_i && (cnt_o != period_i)) |=>
        (cnt_o == $past(cnt_o) + 1'b1));
    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !start_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_pwm_out.sv
// Module: tmr_pwm_out
// Registered compare of the count against the active width. The flop keeps
// the pin free of glitches and holds it steady while the count is frozen.
module tmr_pwm_out #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pwm_o
);
    // Output flop: high while the count is within the width.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_o <= 1'b0;
        else        pwm_o <= en_i && (cnt_i <= width_i);
    end

    p_low_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);
endmodule

// File: rtl/dbg_pwm_timer.sv
// Module: dbg_pwm_timer (top)
// PWM timer with double-buffered period and width and debug-halt gating.
// Assumes a single clock domain and a halt input synchronous to clk.
module dbg_pwm_timer
    import dbg_pwm_timer_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter logic [31:0] RST_COUNT = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              pwm_o,
    output logic              irq_o
);
    localparam int NUM_BUF = 2;

    logic             en, run, start, boundary, ctrl_wr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act [NUM_BUF];

    assign ctrl_wr = bus_wr_i && (bus_addr_i == REG_CTRL);

    tmr_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_wdata_i (bus_wdata_i[CTRL_W-1:0]),
        .boundary_i   (boundary),
        .en_o         (en),
        .run_o        (run),
        .irq_o        (irq_o),
        .start_o      (start)
    );

    // One shadow/active pair per buffered register: index 0 period, 1 width.
    for (genvar gi = 0; gi < NUM_BUF; gi++) begin : g_buf
        localparam logic [ADDR_W-1:0] SEL = ADDR_W'(int'(REG_PERIOD) + gi);
        tmr_shadow_reg #(.DATA_W(CNT_W)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (bus_wr_i && (bus_addr_i == SEL)),
            .wdata_i    (bus_wdata_i),
            .en_i       (en),
            .boundary_i (boundary),
            .active_o   (act[gi])
        );
    end

    tmr_count #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .run_i      (run),
        .start_i    (start),
        .halt_i     (dbg_halt_i),
        .period_i   (act[0]),
        .cnt_o      (cnt),
        .boundary_o (boundary)
    );

    tmr_pwm_out #(.CNT_W(CNT_W)) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .cnt_i   (cnt),
        .width_i (act[1]),
        .pwm_o   (pwm_o)
    );

    // Read mux: the selected register is returned in the same clock.
    always_comb begin
        bus_rdata_o = '0;
        case (reg_addr_e'(bus_addr_i))
            REG_CTRL: begin
                bus_rdata_o[CTRL_EN_BIT]  = en;
                bus_rdata_o[CTRL_RUN_BIT] = run;
                bus_rdata_o[CTRL_IRQ_BIT] = irq_o;
            end
            REG_PERIOD: bus_rdata_o = act[0];
            REG_WIDTH:  bus_rdata_o = act[1];
            REG_COUNT:  bus_rdata_o = cnt;
            default:    bus_rdata_o = '0;
        endcase
    end

    p_pwm_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dbg_halt_i && !run && $past(en && dbg_halt_i && !run))
        |=> $stable(pwm_o));
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt == act[0]) && (!dbg_halt_i || run)) |=> (cnt == CNT_W'(RST_COUNT)));
endmodule

// File: tb/dbg_pwm_timer_tb.sv
`timescale 1ns/1ps
module dbg_pwm_timer_tb;
    import dbg_pwm_timer_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt = 1'b0;
    logic         wr = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         pwm, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_halt_i(halt),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
    );

    typedef struct packed {
        logic [31:0] period;
        logic [31:0] width;
        logic [31:0] high;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{32'd8,  32'd3, 32'd3},
        '{32'd10, 32'd0, 32'd0},
        '{32'd6,  32'd6, 32'd6},
        '{32'd5,  32'd9, 32'd5},
        '{32'd16, 32'd1, 32'd1}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_count(input logic [W-1:0] target);
        logic [W-1:0] v;
        for (int i = 0; i < 200; i++) begin
            bus_read(REG_COUNT, v);
            if (v == target) return;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v, c0;
        int hi;
        logic [W-1:0] mx;
        logic p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(REG_COUNT, v);  chk("R1 count", v, 32'd1);
        bus_read(REG_CTRL, v);   chk("R1 ctrl", v, 32'd0);
        bus_read(REG_PERIOD, v); chk("R1 period", v, 32'd0);
        bus_read(REG_WIDTH, v);  chk("R1 width", v, 32'd0);
        chk("R1 pwm", {31'd0, pwm}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // Duty-cycle table: R7 direct writes, R4 duty, R3 wrap bound
        for (int k = 0; k < NVEC; k++) begin
            bus_write(REG_CTRL, 32'd0);
            bus_write(REG_PERIOD, VECS[k].period);
            bus_write(REG_WIDTH, VECS[k].width);
            bus_read(REG_PERIOD, v); chk("R7 period direct", v, VECS[k].period);
            bus_read(REG_WIDTH, v);  chk("R7 width direct", v, VECS[k].width);
            bus_write(REG_CTRL, 32'd1);
            repeat (3) @(negedge clk);
            hi = 0; mx = 0;
            for (int i = 0; i < int'(VECS[k].period); i++) begin
                if (pwm) hi++;
                bus_read(REG_COUNT, v);
                if (v > mx) mx = v;
                @(negedge clk);
            end
            chk("R4 high clocks", W'(hi), VECS[k].high);
            chk("R3 max count", mx, VECS[k].period);
        end

        // R2 start from 1 and step
        bus_write(REG_CTRL, 32'd0);
        bus_write(REG_PERIOD, 32'd1000);
        bus_write(REG_WIDTH, 32'd500);
        bus_write(REG_CTRL, 32'd5);
        bus_read(REG_COUNT, v); chk("R2 start count", v, 32'd1);
        @(negedge clk);
        bus_read(REG_COUNT, v); chk("R2 step", v, 32'd2);
        chk("R10 flag cleared by write", {31'd0, irq}, 32'd0);

        // R8 halt freezes count and pwm
        repeat (5) @(negedge clk);
        halt = 1'b1;
        bus_read(REG_COUNT, c0);
        p0 = pwm;
        repeat (6) @(negedge clk);
        bus_read(REG_COUNT, v); chk("R8 count frozen", v, c0);
        chk("R8 pwm frozen", {31'd0, pwm}, {31'd0, p0});
        // R10 register write works during halt (disabled path)
        bus_write(REG_CTRL, 32'd0);
        bus_write(REG_WIDTH, 32'd77);
        bus_read(REG_WIDTH, v); chk("R10 write in halt", v, 32'd77);
        bus_write(REG_WIDTH, 32'd500);
        bus_write(REG_CTRL, 32'd1);

        // R9 run-in-debug keeps counting
        bus_write(REG_CTRL, 32'd3);
        bus_read(REG_COUNT, c0);
        repeat (5) @(negedge clk);
        bus_read(REG_COUNT, v); chk("R9 count runs", v, c0 + 32'd5);
        halt = 1'b0;

        // R5 deferred write, R3 wrap and flag
        bus_write(REG_CTRL, 32'd0);
        bus_write(REG_PERIOD, 32'd20);
        bus_write(REG_CTRL, 32'd1);
        repeat (4) @(negedge clk);
        bus_write(REG_PERIOD, 32'd30);
        bus_read(REG_PERIOD, v); chk("R5 period deferred", v, 32'd20);
        wait_count(32'd20);
        @(negedge clk);
        bus_read(REG_COUNT, v);  chk("R3 wrap to 1", v, 32'd1);
        chk("R3 flag set", {31'd0, irq}, 32'd1);
        bus_read(REG_PERIOD, v); chk("R5 period committed", v, 32'd30);

        // R10 flag persists through a halt
        halt = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(REG_CTRL, v); chk("R10 flag held in halt", {31'd0, v[2]}, 32'd1);
        halt = 1'b0;
        bus_write(REG_CTRL, 32'd5);
        chk("R10 flag clear", {31'd0, irq}, 32'd0);

        // R6 write in the boundary clock
        wait_count(32'd30);
        bus_write(REG_PERIOD, 32'd14);
        bus_read(REG_COUNT, v);  chk("R6 wrap", v, 32'd1);
        bus_read(REG_PERIOD, v); chk("R6 same-edge commit", v, 32'd14);
        bus_write(REG_CTRL, 32'd5);
        chk("R10 clear off boundary", {31'd0, irq}, 32'd0);
        // R10 set wins over clear at the boundary
        wait_count(32'd14);
        bus_write(REG_CTRL, 32'd5);
        bus_read(REG_COUNT, v); chk("R3 wrap at new period", v, 32'd1);
        chk("R10 set beats clear", {31'd0, irq}, 32'd1);

        // R11 disable stops count, pwm low
        repeat (3) @(negedge clk);
        bus_write(REG_CTRL, 32'd0);
        bus_read(REG_COUNT, c0);
        repeat (4) @(negedge clk);
        bus_read(REG_COUNT, v); chk("R11 count stopped", v, c0);
        chk("R11 pwm low", {31'd0, pwm}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule